// File: doc/BRIEF.md
# Shared Cascaded Biquad Filter Engine

This block runs many second-order IIR sections on one multiply-accumulate datapath. Every audio sample period, a single strobe hands it a vector with one signed fixed-point sample per channel. The engine then steps through every (channel, stage) slot. Within a channel it goes stage by stage, and each stage's result becomes the input to the next stage. The last stage of each channel writes that channel's lane of the output vector. A one-cycle completion pulse marks the point where the whole output vector is valid.

Each slot holds its own direct-form-1 history: two past inputs and two past outputs. That history advances once per sample pass, not once per clock. Each slot also has its own coefficient set. A host writes coefficients into a shadow bank, one field at a time. A commit request then makes the whole shadow bank live at the next accepted sample start, so no pass ever runs on a half-written filter. Samples are Q1.22 and coefficients are Q3.20. Products are summed at full precision, and the result is floored and clamped back to 24 bits.

Top module: `biq_mux_engine`

## Requirements
- R1: After synchronous reset, `out_vec` is zero and `busy` and `done` are low. All slot history is zero. Both the shadow and the live coefficient banks hold pass-through: b0 = 0x100000 (1.0) and the other four fields zero, so each output lane equals its input lane.
- R2: Each section computes b0·x + b1·x1 + b2·x2 + a1·y1 + a2·y2. The feedback coefficients carry their own sign and are added. The five 24×24 products are summed without loss, arithmetically shifted right by 20 (floor), and then saturated.
- R3: A section result above 0x7FFFFF is clamped to 0x7FFFFF. A result below -0x800000 is clamped to 0x800000.
- R4: Stage 0 of channel c reads input lane c, which is bits [c*24 +: 24] of `in_vec`. Stage s>0 reads the saturated output of stage s-1 of the same channel. The last stage's result is written to lane c of `out_vec`.
- R5: Slot c*NST+s has its own x1, x2, y1, y2 history. The history shifts exactly once per accepted sample pass.
- R6: A coefficient write goes to the shadow bank only. It addresses slot `coef_slot` (= c*NST+s) and field `coef_field`, coded 0 b0, 1 b1, 2 b2, 3 a1, 4 a2. Field codes 5–7 and slot numbers at or above NCH*NST are ignored.
- R7: After `coef_commit`, the whole shadow bank is copied to the live bank at the next accepted `sample_start`, and that pass uses the new set. A pass already running when the commit arrives finishes on the old set.
- R8: `busy` is high from the cycle after an accepted start. `done` pulses for exactly one cycle, 6·NCH·NST clock edges after the accepted start edge, and `busy` is low when it does.
- R9: `sample_start` asserted while `busy` is high is ignored. It adds no pass, no `done` pulse and no history step.
- R10: `out_vec` stays stable whenever no pass is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_start | input | 1 | Starts a pass over all slots (accepted only when idle) |
| in_vec | input | NCH*DW | One Q1.22 input sample per channel, lane c at [c*DW +: DW] |
| coef_we | input | 1 | Shadow coefficient write enable |
| coef_slot | input | SW | Slot number c*NST+s of the write |
| coef_field | input | 3 | Field code: 0 b0, 1 b1, 2 b2, 3 a1, 4 a2 |
| coef_data | input | CW | Q3.20 coefficient value |
| coef_commit | input | 1 | Requests a shadow-to-live copy at the next accepted start |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse when all output lanes are valid |
| out_vec | output | NCH*DW | Filtered output per channel, lane c at [c*DW +: DW] |

## Verification
The bench builds the engine with two channels and three cascaded stages. That gives six slots and a 36-cycle pass. With these values, the bench can exercise cross-channel lane ordering, stage-to-stage chaining in both the first and the last position, and the channel hand-off in the middle of a pass. It can also place a commit, or a repeated start, at a mid-pass cycle that falls between the slots of different channels. Slot codes 6 and 7 fit in the three-bit slot field but lie outside the bank, so out-of-range writes can be driven on the real port.

// File: rtl/biq_pkg.sv
package biq_pkg;
  localparam int NTAP = 5;

  typedef enum logic [2:0] {
    TAP_B0 = 3'd0,
    TAP_B1 = 3'd1,
    TAP_B2 = 3'd2,
    TAP_A1 = 3'd3,
    TAP_A2 = 3'd4,
    TAP_WB = 3'd5
  } tap_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_e;
endpackage

// File: rtl/biq_coef_bank.sv
module biq_coef_bank #(
  parameter int NSLOT = 6,
  parameter int CW    = 24,
  parameter int CFRAC = 20,
  parameter int SW    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_slot,
  input  logic [2:0]           wr_field,
  input  logic signed [CW-1:0] wr_data,
  input  logic                 commit_req,
  input  logic                 apply,
  input  logic [SW-1:0]        rd_slot,
  input  logic [2:0]           rd_tap,
  output logic signed [CW-1:0] rd_coef,
  output logic                 pending
);
  localparam int NTAP = biq_pkg::NTAP;
  localparam logic [CW-1:0] UNITY = {{(CW-1){1'b0}}, 1'b1} << CFRAC;

  logic signed [CW-1:0] shadow [NSLOT][NTAP];
  logic signed [CW-1:0] active [NSLOT][NTAP];

  // Each word has its own write decode; the live copy happens for the whole bank at once.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    for (genvar t = 0; t < NTAP; t++) begin : g_tap
      localparam logic [CW-1:0] INIT = (t == 0) ? UNITY : '0;
      always_ff @(posedge clk) begin
        if (rst) begin
          shadow[g][t] <= INIT;
          active[g][t] <= INIT;
        end else begin
          if (wr_en && wr_slot == SW'(g) && wr_field == 3'(t))
            shadow[g][t] <= wr_data;
          if (apply && pending)
            active[g][t] <= shadow[g][t];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             pending <= 1'b0;
    else if (commit_req) pending <= 1'b1;
    else if (apply)      pending <= 1'b0;
  end

  always_comb begin
    if (rd_tap < 3'(NTAP)) rd_coef = active[rd_slot][rd_tap];
    else                   rd_coef = '0;
  end
endmodule

// File: rtl/biq_state_mem.sv
module biq_state_mem #(
  parameter int NSLOT = 6,
  parameter int DW    = 24,
  parameter int SW    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SW-1:0]        wr_slot,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] y_in,
  input  logic [SW-1:0]        rd_slot,
  output logic signed [DW-1:0] x1,
  output logic signed [DW-1:0] x2,
  output logic signed [DW-1:0] y1,
  output logic signed [DW-1:0] y2
);
  typedef struct packed {
    logic signed [DW-1:0] x1;
    logic signed [DW-1:0] x2;
    logic signed [DW-1:0] y1;
    logic signed [DW-1:0] y2;
  } hist_t;

  hist_t mem [NSLOT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wr_slot] <= '{x1: x_in, x2: mem[wr_slot].x1,
                        y1: y_in, y2: mem[wr_slot].y1};
    end
  end

  assign x1 = mem[rd_slot].x1;
  assign x2 = mem[rd_slot].x2;
  assign y1 = mem[rd_slot].y1;
  assign y2 = mem[rd_slot].y2;
endmodule

// File: rtl/biq_mac.sv
module biq_mac #(
  parameter int DW    = 24,
  parameter int CW    = 24,
  parameter int CFRAC = 20,
  parameter int AW    = 51
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 clr,
  input  logic signed [CW-1:0] coef,
  input  logic signed [DW-1:0] operand,
  output logic signed [DW-1:0] y_sat
);
  localparam int PW = DW + CW;
  localparam logic signed [AW-1:0] YMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] YMIN = ~YMAX;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] pext;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] shr;

  assign prod = coef * operand;
  assign pext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= (clr ? '0 : acc) + pext;
  end

  assign shr = acc >>> CFRAC;

  always_comb begin
    if (shr > YMAX)      y_sat = YMAX[DW-1:0];
    else if (shr < YMIN) y_sat = YMIN[DW-1:0];
    else                 y_sat = shr[DW-1:0];
  end
endmodule

// File: rtl/biq_seq.sv
module biq_seq #(
  parameter int NCH = 2,
  parameter int NST = 3,
  parameter int DW  = 24,
  parameter int SW  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample_start,
  input  logic [NCH*DW-1:0]    in_vec,
  input  logic signed [DW-1:0] y_sat,
  output logic                 busy,
  output logic                 done,
  output logic [NCH*DW-1:0]    out_vec,
  output logic [SW-1:0]        slot,
  output logic [2:0]           tap,
  output logic signed [DW-1:0] cur_x,
  output logic                 mac_en,
  output logic                 mac_clr,
  output logic                 st_we,
  output logic                 apply
);
  import biq_pkg::*;

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int STW = (NST > 1) ? $clog2(NST) : 1;

  seq_e                 state;
  logic [CHW-1:0]       ch;
  logic [CHW-1:0]       nxt_ch;
  logic [STW-1:0]       st;
  logic [NCH*DW-1:0]    in_buf;
  logic signed [DW-1:0] nxt_in;

  assign busy    = (state == SEQ_RUN);
  assign apply   = sample_start && (state == SEQ_IDLE);
  assign slot    = SW'(int'(ch) * NST + int'(st));
  assign mac_en  = busy && (tap != TAP_WB);
  assign mac_clr = (tap == TAP_B0);
  assign st_we   = busy && (tap == TAP_WB);
  assign nxt_ch  = (int'(ch) == NCH - 1) ? '0 : ch + CHW'(1);
  assign nxt_in  = in_buf[int'(nxt_ch)*DW +: DW];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      ch      <= '0;
      st      <= '0;
      tap     <= '0;
      done    <= 1'b0;
      out_vec <= '0;
      in_buf  <= '0;
      cur_x   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (sample_start) begin
            in_buf <= in_vec;
            cur_x  <= in_vec[DW-1:0];
            ch     <= '0;
            st     <= '0;
            tap    <= '0;
            state  <= SEQ_RUN;
          end
        end
        SEQ_RUN: begin
          if (tap != TAP_WB) begin
            tap <= tap + 3'd1;
          end else begin
            tap <= '0;
            if (int'(st) == NST - 1) begin
              out_vec[int'(ch)*DW +: DW] <= y_sat;
              st    <= '0;
              ch    <= nxt_ch;
              cur_x <= nxt_in;
              if (int'(ch) == NCH - 1) begin
                state <= SEQ_IDLE;
                done  <= 1'b1;
              end
            end else begin
              st    <= st + STW'(1);
              cur_x <= y_sat;
            end
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/biq_mux_engine.sv
module biq_mux_engine #(
  parameter int NCH   = 2,
  parameter int NST   = 3,
  parameter int DW    = 24,
  parameter int CW    = 24,
  parameter int CFRAC = 20,
  localparam int NSLOT = NCH * NST,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int AW    = DW + CW + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_start,
  input  logic [NCH*DW-1:0] in_vec,
  input  logic              coef_we,
  input  logic [SW-1:0]     coef_slot,
  input  logic [2:0]        coef_field,
  input  logic [CW-1:0]     coef_data,
  input  logic              coef_commit,
  output logic              busy,
  output logic              done,
  output logic [NCH*DW-1:0] out_vec
);
  import biq_pkg::*;

  logic [SW-1:0]        slot;
  logic [2:0]           tap;
  logic signed [DW-1:0] cur_x;
  logic signed [DW-1:0] h_x1, h_x2, h_y1, h_y2;
  logic signed [DW-1:0] operand;
  logic signed [DW-1:0] y_sat;
  logic signed [CW-1:0] coef;
  logic                 mac_en, mac_clr, st_we, apply;
  logic                 coef_pending;

  biq_seq #(.NCH(NCH), .NST(NST), .DW(DW), .SW(SW)) u_seq (
    .clk(clk), .rst(rst), .sample_start(sample_start), .in_vec(in_vec),
    .y_sat(y_sat), .busy(busy), .done(done), .out_vec(out_vec),
    .slot(slot), .tap(tap), .cur_x(cur_x), .mac_en(mac_en),
    .mac_clr(mac_clr), .st_we(st_we), .apply(apply)
  );

  biq_coef_bank #(.NSLOT(NSLOT), .CW(CW), .CFRAC(CFRAC), .SW(SW)) u_bank (
    .clk(clk), .rst(rst), .wr_en(coef_we), .wr_slot(coef_slot),
    .wr_field(coef_field), .wr_data(coef_data), .commit_req(coef_commit),
    .apply(apply), .rd_slot(slot), .rd_tap(tap), .rd_coef(coef),
    .pending(coef_pending)
  );

  biq_state_mem #(.NSLOT(NSLOT), .DW(DW), .SW(SW)) u_hist (
    .clk(clk), .rst(rst), .we(st_we), .wr_slot(slot), .x_in(cur_x),
    .y_in(y_sat), .rd_slot(slot), .x1(h_x1), .x2(h_x2), .y1(h_y1), .y2(h_y2)
  );

  always_comb begin
    case (tap)
      TAP_B0:  operand = cur_x;
      TAP_B1:  operand = h_x1;
      TAP_B2:  operand = h_x2;
      TAP_A1:  operand = h_y1;
      TAP_A2:  operand = h_y2;
      default: operand = '0;
    endcase
  end

  biq_mac #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .AW(AW)) u_mac (
    .clk(clk), .rst(rst), .en(mac_en), .clr(mac_clr), .coef(coef),
    .operand(operand), .y_sat(y_sat)
  );
endmodule

// File: rtl/biq_engine_chk.sv
module biq_engine_chk #(
  parameter int OW = 48
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          sample_start,
  input logic [OW-1:0] out_vec,
  input logic          pending
);
  // R8: completion is a single-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: completion is never flagged while a pass runs
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: completion only follows a running pass
  assert_done_after_run_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  // R10: outputs hold while idle
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(out_vec));

  // R7: a pending commit is consumed only by an accepted start
  assert_commit_at_start_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> ($past(sample_start && !busy) || $past(rst)));
endmodule

bind biq_mux_engine biq_engine_chk #(.OW(NCH*DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done),
  .sample_start(sample_start), .out_vec(out_vec), .pending(coef_pending)
);

// File: tb/biq_mux_engine_tb.sv
module biq_mux_engine_tb;
  localparam int NCH = 2;
  localparam int NST = 3;
  localparam int NSL = NCH * NST;
  localparam int PASS_CYC = 6 * NSL;
  localparam longint YMAX = 8388607;
  localparam longint YMIN = -8388608;

  // Stimulus table: {lane0, lane1}; expected lanes come from the reference model.
  localparam int NVEC = 12;
  localparam int STIM [NVEC][2] = '{
    '{ 4194303,        0}, '{       0,  1048576}, '{       0,        0},
    '{-2097152,  2097152}, '{ 3000000, -3000000}, '{ 3000000, -3000000},
    '{-4194304,  4194303}, '{  123456,   -65432}, '{ 1048576,  1048576},
    '{-1048576, -1048576}, '{ 2500000,    77777}, '{       0,        0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sample_start = 1'b0;
  logic [NCH*24-1:0] in_vec = '0;
  logic              coef_we = 1'b0;
  logic [2:0]        coef_slot = '0;
  logic [2:0]        coef_field = '0;
  logic [23:0]       coef_data = '0;
  logic              coef_commit = 1'b0;
  logic              busy, done;
  logic [NCH*24-1:0] out_vec;

  int     errs = 0;
  int     nchk = 0;
  int     cyc_cnt = 0;
  int     start_cnt = 0;
  longint m_sh [NSL][5];
  longint m_act [NSL][5];
  longint m_hx1 [NSL], m_hx2 [NSL], m_hy1 [NSL], m_hy2 [NSL];
  longint exp_o [NCH];
  bit     m_pend;

  always #4 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  biq_mux_engine #(.NCH(NCH), .NST(NST)) u_dut (
    .clk(clk), .rst(rst), .sample_start(sample_start), .in_vec(in_vec),
    .coef_we(coef_we), .coef_slot(coef_slot), .coef_field(coef_field),
    .coef_data(coef_data), .coef_commit(coef_commit), .busy(busy),
    .done(done), .out_vec(out_vec)
  );

  task automatic check(input string req, input longint act, input longint expv);
    nchk++;
    if (act !== expv) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint lane(input int c);
    return longint'($signed(out_vec[c*24 +: 24]));
  endfunction

  task automatic model_reset();
    for (int s = 0; s < NSL; s++) begin
      for (int f = 0; f < 5; f++) begin
        m_sh[s][f]  = (f == 0) ? 1048576 : 0;
        m_act[s][f] = m_sh[s][f];
      end
      m_hx1[s] = 0; m_hx2[s] = 0; m_hy1[s] = 0; m_hy2[s] = 0;
    end
    m_pend = 1'b0;
  endtask

  // Reference: floor shift by 20, clamp to 24 bits, stage chaining per channel
  task automatic model_step(input int i0, input int i1);
    longint x, acc, y;
    if (m_pend) begin
      m_act  = m_sh;
      m_pend = 1'b0;
    end
    for (int c = 0; c < NCH; c++) begin
      x = (c == 0) ? longint'(i0) : longint'(i1);
      for (int s = 0; s < NST; s++) begin
        int k = c * NST + s;
        acc = m_act[k][0]*x + m_act[k][1]*m_hx1[k] + m_act[k][2]*m_hx2[k]
            + m_act[k][3]*m_hy1[k] + m_act[k][4]*m_hy2[k];
        y = acc >>> 20;
        if (y > YMAX) y = YMAX;
        if (y < YMIN) y = YMIN;
        m_hx2[k] = m_hx1[k]; m_hx1[k] = x;
        m_hy2[k] = m_hy1[k]; m_hy1[k] = y;
        x = y;
      end
      exp_o[c] = x;
    end
  endtask

  task automatic write_coef(input int s, input int f, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_slot = 3'(s); coef_field = 3'(f); coef_data = 24'(v);
    @(negedge clk);
    coef_we = 1'b0;
    if (s < NSL && f < 5) m_sh[s][f] = longint'(v);
  endtask

  task automatic commit();
    @(negedge clk);
    coef_commit = 1'b1;
    @(negedge clk);
    coef_commit = 1'b0;
    m_pend = 1'b1;
  endtask

  task automatic start_pass(input int i0, input int i1);
    @(negedge clk);
    in_vec = {24'(i1), 24'(i0)};
    sample_start = 1'b1;
    @(posedge clk);
    model_step(i0, i1);
    @(negedge clk);
    sample_start = 1'b0;
    start_cnt = cyc_cnt;
  endtask

  task automatic finish_pass(input string req);
    int guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check("R8 done latency", longint'(cyc_cnt - start_cnt), PASS_CYC);
    for (int c = 0; c < NCH; c++) check(req, lane(c), exp_o[c]);
  endtask

  task automatic load_main_set();
    for (int s = 0; s < NSL; s++) begin
      write_coef(s, 0, 262144);
      write_coef(s, 1, 524288);
      write_coef(s, 2, 262144);
      write_coef(s, 3, 786432 - s * 65536);
      write_coef(s, 4, -262144);
    end
  endtask

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 out_vec", longint'(out_vec), 0);
    check("R1 busy", longint'(busy), 0);
    check("R1 done", longint'(done), 0);

    // R1: pass-through default coefficients
    start_pass(1193046, -703710);
    check("R8 busy after start", longint'(busy), 1);
    finish_pass("R1 pass-through");
    check("R1 lane0 equals input", lane(0), 1193046);

    // R6: shadow-only writes plus ignored field/slot codes
    load_main_set();
    write_coef(0, 7, 999999);
    write_coef(7, 0, 12345);
    write_coef(6, 3, 54321);
    start_pass(500000, -400000);
    finish_pass("R6 shadow not live");
    check("R6 lane1 still pass-through", lane(1), -400000);

    // R2 R4 R5 R7: committed set, table walk against reference
    commit();
    for (int i = 0; i < NVEC; i++) begin
      start_pass(STIM[i][0], STIM[i][1]);
      finish_pass("R2 R4 R5 table output");
    end

    // R7: commit during a running pass is deferred to the next start
    start_pass(700000, 300000);
    write_coef(0, 0, 524288);
    write_coef(3, 4, -131072);
    commit();
    finish_pass("R7 old set during pass");
    start_pass(700000, 300000);
    finish_pass("R7 new set after start");

    // R9: start while busy is ignored
    start_pass(-900000, 1100000);
    repeat (8) @(negedge clk);
    in_vec = {24'(12345), 24'(-54321)};
    sample_start = 1'b1;
    @(negedge clk);
    sample_start = 1'b0;
    finish_pass("R9 single pass output");
    begin
      int extra = 0;
      for (int k = 0; k < PASS_CYC + 10; k++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R9 no extra done", longint'(extra), 0);
      check("R10 out held lane0", lane(0), exp_o[0]);
    end
    start_pass(0, 0);
    finish_pass("R9 history stepped once");

    // R3: saturation, gain near 4 at stage 0, others pass-through
    for (int s = 0; s < NSL; s++) begin
      write_coef(s, 0, (s % NST == 0) ? 4194303 : 1048576);
      for (int f = 1; f < 5; f++) write_coef(s, f, 0);
    end
    commit();
    start_pass(3145728, -3145728);
    finish_pass("R3 clamp model");
    check("R3 positive clamp", lane(0), YMAX);
    check("R3 negative clamp", lane(1), YMIN);

    // R1: reset mid-life clears history and restores pass-through
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 out cleared", longint'(out_vec), 0);
    start_pass(-222222, 333333);
    finish_pass("R1 after reset");
    check("R1 lane1 pass-through", lane(1), 333333);

    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule